// File: doc/BRIEF.md
# First-Fault Predicated Byte Vector Load Sequencer

This block runs one predicated, first-fault vector load. A start pulse captures a base address, an element index offset, a per-byte predicate and an element-width select. The block then walks the elements in ascending order. For each active element it issues a single one-byte read to a memory port that allows one outstanding request. Each returned byte is zero-extended into its lane of a result vector. Inactive lanes stay zero and never reach memory.

A fault reported on the first active element is a real fault. The block aborts with a one-cycle trap pulse and leaves its published result and fault-status vector as they were. A fault on any later active element is suppressed. The status bit of that element and of every later element is cleared, its lane and all later lanes stay zero, and the sequencer stops issuing requests and completes. On completion the result vector and the per-element status vector (FFR) are published together with a one-cycle done pulse.

Top module: `ffld_seq`

## Requirements
- R1: Element e reads the single byte at address base + offset + e, computed modulo 2^64. Consecutive active elements read consecutive increasing addresses.
- R2: An element whose predicate bit is 0 issues no memory request and cannot fault. Its lane in the result is zero, even when its address is one that would fault.
- R3: A fault on the first active element produces a one-cycle trap_o pulse and no done_o. result_o and ffr_o keep the values they had before the operation.
- R4: A fault on a later active element is suppressed: done_o pulses, trap_o stays low, and ffr_o bit e is 1 exactly for elements below the faulting one.
- R5: After a suppressed fault no further memory request is issued, so the request count is the number of active elements up to and including the faulting one.
- R6: The result lane of the faulting element and of every later element is zero.
- R7: esize_i selects the element width: 0 = 8 bits, 1 = 16, 2 = 32, 3 = 64. There are VLEN/width elements. Lane e occupies bits [e*width +: width] of result_o, and the loaded byte sits in its low 8 bits with the upper bits zero. Without any fault, ffr_o bit e is 1 for every e below the element count and 0 above it.
- R8: Element e is active when predicate bit e*(width/8) is 1. The other predicate bits of its group are ignored.
- R9: With no active element the block issues no request and completes with an all-zero result and ffr_o set for all elements.
- R10: mem_req_valid_o, once raised, stays high with a stable address until mem_req_ready_i is seen. No new request is raised while a response is outstanding.
- R11: start_i is ignored while busy_o is high. The running operation's result is unaffected.
- R12: done_o and trap_o are single-cycle pulses and never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken when idle |
| base_i | input | AW | Base byte address |
| offset_i | input | AW | Element index offset |
| pred_i | input | VLEN/8 | Predicate, one bit per byte |
| esize_i | input | 2 | Element width select |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | AW | Read byte address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 8 | Read response byte |
| mem_rsp_fault_i | input | 1 | Read response fault flag |
| result_o | output | VLEN | Published result vector |
| ffr_o | output | VLEN/8 | Published per-element status, bit e for element e |
| done_o | output | 1 | Completion pulse |
| trap_o | output | 1 | First-element fault pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
Full byte predicates at every element width separate the lane placement and the zero-extension. A base near the top of the address space exposes wrap errors in the address sum. Sparse predicates with set bits in non-lowest group positions show whether activity is decided by the right bit. A faulting address placed on an inactive element, on the first active element and on a later active element distinguishes ignored, trapping and suppressed faults. Checking the request count tells whether the sequencer stopped after suppression. A stalling ready pattern and a start pulse issued mid-run test the handshake hold and the busy interlock.

// File: rtl/ffld_pkg.sv
package ffld_pkg;

  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esz_e;

  // number of elements of a vector that holds ne bytes
  function automatic int elem_count(int ne, logic [1:0] esz);
    return ne >> esz;
  endfunction

  // predicate bit position that governs element e
  function automatic int gate_bit(int e, logic [1:0] esz);
    return e << esz;
  endfunction

endpackage

// File: rtl/ffld_scan.sv
module ffld_scan
  import ffld_pkg::*;
#(
  parameter int NE = 16,
  localparam int IW = $clog2(NE)
) (
  input  logic [NE-1:0] pred_i,
  input  logic [1:0]    esz_i,
  input  logic [IW:0]   from_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  // lowest active element at or above from_i
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int e = NE - 1; e >= 0; e--) begin
      if (e < elem_count(NE, esz_i) && e >= int'(from_i) &&
          pred_i[gate_bit(e, esz_i) % NE]) begin
        found_o = 1'b1;
        idx_o   = IW'(e);
      end
    end
  end

endmodule

// File: rtl/ffld_lane_merge.sv
module ffld_lane_merge #(
  parameter int NE = 16,
  localparam int IW = $clog2(NE)
) (
  input  logic [NE*8-1:0] vec_i,
  input  logic [1:0]      esz_i,
  input  logic [IW-1:0]   idx_i,
  input  logic [7:0]      data_i,
  output logic [NE*8-1:0] vec_o
);

  for (genvar k = 0; k < NE; k++) begin : g_byte
    logic [IW-1:0] lane;
    logic [2:0]    sub;
    logic [7:0]    byte_q;
    assign lane   = IW'(k >> esz_i);
    assign sub    = 3'(k & ((1 << esz_i) - 1));
    // low byte of the lane takes the data, upper bytes are zero-extension
    assign byte_q = (lane != idx_i) ? vec_i[k*8 +: 8] :
                    (sub == 3'd0)   ? data_i : 8'h00;
    assign vec_o[k*8 +: 8] = byte_q;
  end

endmodule

// File: rtl/ffld_mem_port.sv
module ffld_mem_port #(
  parameter int AW = 64,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [AW-1:0] addr_i,
  output logic          req_valid_o,
  input  logic          req_ready_i,
  output logic [AW-1:0] req_addr_o,
  input  logic          rsp_valid_i,
  input  logic [DW-1:0] rsp_data_i,
  input  logic          rsp_fault_i,
  output logic          rsp_evt_o,
  output logic [DW-1:0] rsp_data_o,
  output logic          rsp_fault_o,
  output logic          outstanding_o
);

  logic          pend_q;
  logic          wait_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= 1'b0;
      addr_q <= '0;
    end else if (issue_i) begin
      pend_q <= 1'b1;
      addr_q <= addr_i;
    end else if (pend_q && req_ready_i) begin
      pend_q <= 1'b0;
      wait_q <= 1'b1;
    end else if (wait_q && rsp_valid_i) begin
      wait_q <= 1'b0;
    end
  end

  assign req_valid_o   = pend_q;
  assign req_addr_o    = addr_q;
  assign rsp_evt_o     = wait_q && rsp_valid_i;
  assign rsp_data_o    = rsp_data_i;
  assign rsp_fault_o   = rsp_fault_i;
  assign outstanding_o = wait_q;

endmodule

// File: rtl/ffld_seq.sv
module ffld_seq
  import ffld_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int AW   = 64,
  localparam int NE  = VLEN / 8,
  localparam int IW  = $clog2(NE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   offset_i,
  input  logic [NE-1:0]   pred_i,
  input  logic [1:0]      esize_i,
  output logic            mem_req_valid_o,
  input  logic            mem_req_ready_i,
  output logic [AW-1:0]   mem_req_addr_o,
  input  logic            mem_rsp_valid_i,
  input  logic [7:0]      mem_rsp_data_i,
  input  logic            mem_rsp_fault_i,
  output logic [VLEN-1:0] result_o,
  output logic [NE-1:0]   ffr_o,
  output logic            done_o,
  output logic            trap_o,
  output logic            busy_o
);

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_WAIT} st_e;

  function automatic logic [NE-1:0] count_mask(logic [1:0] s);
    logic [NE-1:0] m;
    for (int e = 0; e < NE; e++) m[e] = (e < elem_count(NE, s));
    return m;
  endfunction

  function automatic logic [NE-1:0] below_mask(logic [IW-1:0] i);
    logic [NE-1:0] m;
    for (int e = 0; e < NE; e++) m[e] = (e < int'(i));
    return m;
  endfunction

  function automatic logic [AW-1:0] elem_addr(logic [AW-1:0] b, logic [AW-1:0] o,
                                               logic [IW-1:0] e);
    return b + o + AW'(e);
  endfunction

  st_e             st_q;
  logic [AW-1:0]   base_q, off_q;
  logic [NE-1:0]   pred_q;
  logic [1:0]      esz_q;
  logic [IW:0]     pos_q;
  logic [IW-1:0]   cur_q;
  logic            first_q;
  logic [VLEN-1:0] res_q;
  logic [NE-1:0]   ffr_q;

  logic            found_w;
  logic [IW-1:0]   nidx_w;
  logic [VLEN-1:0] merged_w;
  logic            issue_w;
  logic            rsp_evt_w, rsp_fault_w, outstanding_w;
  logic [7:0]      rsp_data_w;
  logic            first_fault_w, sup_fault_w, load_ok_w, empty_w;

  ffld_scan #(.NE(NE)) u_scan (
    .pred_i (pred_q),
    .esz_i  (esz_q),
    .from_i (pos_q),
    .found_o(found_w),
    .idx_o  (nidx_w)
  );

  ffld_lane_merge #(.NE(NE)) u_merge (
    .vec_i (res_q),
    .esz_i (esz_q),
    .idx_i (cur_q),
    .data_i(rsp_data_w),
    .vec_o (merged_w)
  );

  ffld_mem_port #(.AW(AW), .DW(8)) u_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_i      (issue_w),
    .addr_i       (elem_addr(base_q, off_q, nidx_w)),
    .req_valid_o  (mem_req_valid_o),
    .req_ready_i  (mem_req_ready_i),
    .req_addr_o   (mem_req_addr_o),
    .rsp_valid_i  (mem_rsp_valid_i),
    .rsp_data_i   (mem_rsp_data_i),
    .rsp_fault_i  (mem_rsp_fault_i),
    .rsp_evt_o    (rsp_evt_w),
    .rsp_data_o   (rsp_data_w),
    .rsp_fault_o  (rsp_fault_w),
    .outstanding_o(outstanding_w)
  );

  // named events for the checker
  assign issue_w       = (st_q == ST_SCAN) && found_w;
  assign empty_w       = (st_q == ST_SCAN) && !found_w;
  assign first_fault_w = (st_q == ST_WAIT) && rsp_evt_w && rsp_fault_w && first_q;
  assign sup_fault_w   = (st_q == ST_WAIT) && rsp_evt_w && rsp_fault_w && !first_q;
  assign load_ok_w     = (st_q == ST_WAIT) && rsp_evt_w && !rsp_fault_w;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      base_q   <= '0;
      off_q    <= '0;
      pred_q   <= '0;
      esz_q    <= '0;
      pos_q    <= '0;
      cur_q    <= '0;
      first_q  <= 1'b0;
      res_q    <= '0;
      ffr_q    <= '0;
      result_o <= '0;
      ffr_o    <= '0;
      done_o   <= 1'b0;
      trap_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      trap_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            base_q  <= base_i;
            off_q   <= offset_i;
            pred_q  <= pred_i;
            esz_q   <= esize_i;
            pos_q   <= '0;
            first_q <= 1'b1;
            res_q   <= '0;
            ffr_q   <= count_mask(esize_i);
            st_q    <= ST_SCAN;
          end
        end
        ST_SCAN: begin
          if (found_w) begin
            cur_q <= nidx_w;
            st_q  <= ST_WAIT;
          end else if (empty_w) begin
            result_o <= res_q;
            ffr_o    <= ffr_q;
            done_o   <= 1'b1;
            st_q     <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (load_ok_w) begin
            res_q   <= merged_w;
            first_q <= 1'b0;
            pos_q   <= {1'b0, cur_q} + 1'b1;
            st_q    <= ST_SCAN;
          end else if (first_fault_w) begin
            trap_o <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (sup_fault_w) begin
            result_o <= res_q;
            ffr_o    <= ffr_q & below_mask(cur_q);
            done_o   <= 1'b1;
            st_q     <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != ST_IDLE);

endmodule

// File: rtl/ffld_seq_chk.sv
module ffld_seq_chk #(
  parameter int VLEN = 128,
  parameter int AW   = 64,
  localparam int NE  = VLEN / 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [AW-1:0]   req_addr,
  input logic            outstanding,
  input logic            sup_fault,
  input logic            done,
  input logic            trap,
  input logic [VLEN-1:0] result,
  input logic [NE-1:0]   ffr
);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  assert_single_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !req_valid);

  assert_trap_keeps_outputs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> ($stable(result) && $stable(ffr)));

  assert_ffr_prefix_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((ffr & (ffr + 1'b1)) == '0));

  assert_quiet_after_suppress_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sup_fault |=> !req_valid);

  assert_done_trap_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && trap));

  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_trap_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    trap |=> !trap);

endmodule

bind ffld_seq ffld_seq_chk #(.VLEN(VLEN), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (mem_req_valid_o),
  .req_ready  (mem_req_ready_i),
  .req_addr   (mem_req_addr_o),
  .outstanding(outstanding_w),
  .sup_fault  (sup_fault_w),
  .done       (done_o),
  .trap       (trap_o),
  .result     (result_o),
  .ffr        (ffr_o)
);

// File: tb/ffld_seq_bench.sv
module ffld_seq_bench;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [63:0]  base_i = '0, offset_i = '0;
  logic [15:0]  pred_i = '0;
  logic [1:0]   esize_i = '0;
  logic         mem_req_valid_o;
  logic         mem_req_ready_i = 1'b0;
  logic [63:0]  mem_req_addr_o;
  logic         mem_rsp_valid_i = 1'b0;
  logic [7:0]   mem_rsp_data_i = '0;
  logic         mem_rsp_fault_i = 1'b0;
  logic [127:0] result_o;
  logic [15:0]  ffr_o;
  logic         done_o, trap_o, busy_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ffld_seq u_ffld_seq (.*);

  // memory model
  logic        acc_pend = 1'b0;
  logic [63:0] acc_addr = '0;
  int          nreq = 0;
  int          rdy_cnt = 0;
  bit          stall_mode = 1'b0;
  bit          fault_en = 1'b0;
  logic [63:0] fault_addr = '0;

  function automatic logic [7:0] mem_byte(logic [63:0] a);
    return a[7:0] + a[63:56] + 8'h3C;
  endfunction

  always @(negedge clk) begin
    mem_rsp_valid_i = acc_pend;
    mem_rsp_data_i  = acc_pend ? mem_byte(acc_addr) : 8'h00;
    mem_rsp_fault_i = acc_pend && fault_en && (acc_addr == fault_addr);
    rdy_cnt++;
    mem_req_ready_i = stall_mode ? ((rdy_cnt % 3) == 0) : 1'b1;
    acc_pend = mem_req_valid_o && mem_req_ready_i;
    if (acc_pend) begin
      acc_addr = mem_req_addr_o;
      nreq++;
    end
  end

  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic exp_calc(input logic [63:0] b, input logic [63:0] o, input logic [15:0] p,
                          input int esz, output logic [127:0] res, output logic [15:0] ffr,
                          output bit trap, output int cnt_req);
    int  bytes = 1 << esz;
    int  cnt   = 16 >> esz;
    bit  first = 1'b1;
    bit  stop  = 1'b0;
    res = '0; ffr = '0; trap = 1'b0; cnt_req = 0;
    for (int e = 0; e < cnt; e++) ffr[e] = 1'b1;
    for (int e = 0; e < cnt; e++) begin
      if (!stop && p[e*bytes]) begin
        logic [63:0] a = b + o + 64'(e);
        cnt_req++;
        if (fault_en && a == fault_addr) begin
          if (first) trap = 1'b1;
          else for (int k = e; k < 16; k++) ffr[k] = 1'b0;
          stop = 1'b1;
        end else begin
          res[e*bytes*8 +: 8] = mem_byte(a);
          first = 1'b0;
        end
      end
    end
  endtask

  task automatic run_case(string tag, logic [63:0] b, logic [63:0] o, logic [15:0] p,
                          int esz, bit stall, bit fen, logic [63:0] fa, bit mid_start);
    logic [127:0] eres, pres;
    logic [15:0]  effr, pffr;
    bit           etrap, saw_done, saw_trap, busy_seen;
    int           ereq;
    @(negedge clk);
    stall_mode = stall; fault_en = fen; fault_addr = fa;
    pres = result_o; pffr = ffr_o;
    exp_calc(b, o, p, esz, eres, effr, etrap, ereq);
    if (etrap) begin eres = pres; effr = pffr; end
    nreq = 0;
    base_i = b; offset_i = o; pred_i = p; esize_i = 2'(esz); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    saw_done = 1'b0; saw_trap = 1'b0; busy_seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (mid_start && i == 3) begin
        busy_seen = busy_o;
        start_i = 1'b1; pred_i = ~p; esize_i = 2'd0; base_i = b + 64'h40;
      end
      if (mid_start && i == 4) start_i = 1'b0;
      @(negedge clk);
      if (done_o || trap_o) begin
        saw_done = done_o; saw_trap = trap_o;
        break;
      end
    end
    chk(tag, "trap pulse", 128'(saw_trap), 128'(etrap));
    chk(tag, "done pulse", 128'(saw_done), 128'(!etrap));
    chk(tag, "result", result_o, eres);
    chk(tag, "ffr", 128'(ffr_o), 128'(effr));
    chk(tag, "request count", 128'(nreq), 128'(ereq));
    if (mid_start) chk("R11", "busy at restart attempt", 128'(busy_seen), 128'(1));
    @(negedge clk);
    chk("R12", "pulse ends", 128'(done_o || trap_o), 128'(0));
    chk("R11", "idle after end", 128'(busy_o), 128'(0));
  endtask

  // scenarios
  task automatic t_reset();
    chk("R12", "reset done", 128'(done_o), 128'(0));
    chk("R12", "reset trap", 128'(trap_o), 128'(0));
    chk("R10", "reset req", 128'(mem_req_valid_o), 128'(0));
    chk("R11", "reset busy", 128'(busy_o), 128'(0));
    chk("R7", "reset result", result_o, 128'(0));
    chk("R7", "reset ffr", 128'(ffr_o), 128'(0));
  endtask

  task automatic t_bytes_full();
    run_case("R1 R7", 64'h1000, 64'h20, 16'hFFFF, 0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic t_wrap_stall();
    run_case("R1 R10", 64'hFFFF_FFFF_FFFF_FFF8, 64'h4, 16'hFFFF, 0, 1'b1, 1'b0, '0, 1'b0);
  endtask

  task automatic t_gate_bits();
    // element 0 has only bit 1 set, so it is inactive; elements 2 and 3 active
    run_case("R8 R2", 64'h2000, 64'h3, 16'h1102, 2, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic t_wide();
    run_case("R7", 64'h7700_0000_0000_0100, 64'h10, 16'h0101, 3, 1'b1, 1'b0, '0, 1'b0);
    run_case("R7", 64'h3000, 64'h0, 16'h5555, 1, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic t_suppress();
    // 16-bit elements, fault on element 3
    run_case("R4 R5 R6", 64'h4000, 64'h8, 16'h5555, 1, 1'b0, 1'b1, 64'h400B, 1'b0);
    // inactive elements after the fault; fault on element 5 of byte elements
    run_case("R4 R5 R6", 64'h5000, 64'h0, 16'h0F3B, 0, 1'b1, 1'b1, 64'h5005, 1'b0);
  endtask

  task automatic t_first_fault();
    run_case("R3", 64'h6000, 64'h0, 16'hFFF0, 0, 1'b0, 1'b1, 64'h6004, 1'b0);
  endtask

  task automatic t_none_active();
    run_case("R9", 64'h7000, 64'h0, 16'h0000, 0, 1'b0, 1'b0, '0, 1'b0);
  endtask

  task automatic t_inactive_fault();
    run_case("R2", 64'h8000, 64'h1, 16'hFFFE, 0, 1'b0, 1'b1, 64'h8001, 1'b0);
  endtask

  task automatic t_busy_start();
    run_case("R11", 64'h9000, 64'h2, 16'hFFFF, 0, 1'b1, 1'b0, '0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes_full();
    t_wrap_stall();
    t_gate_bits();
    t_wide();
    t_suppress();
    t_first_fault();
    t_none_active();
    t_inactive_fault();
    t_busy_start();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule